// File: doc/BRIEF.md
# CPU Status and Stack Pointer Register Unit

This block holds the processor's 8-bit status byte and its 16-bit stack pointer. The status byte carries a global interrupt enable, a one-bit transfer cell used by bit-copy instructions, and six arithmetic flags. The ALU reports carry, zero, negative, overflow and half-carry together with one update enable per flag, so each operation changes only the flags it affects. The sign flag is never stored. It is always formed as negative XOR overflow, so it stays consistent after ALU updates and after direct writes.

The global interrupt enable is a two-state machine, `IE_MASKED` and `IE_OPEN`, and it resets to `IE_MASKED`. It has three transitions:
- ACCEPT: any state goes to `IE_MASKED` when an interrupt is taken.
- LOAD: the state follows bit 7 of an I/O write to the status byte.
- RETURN: `IE_MASKED` goes to `IE_OPEN` on a return-from-interrupt strobe.

While the machine is in `IE_MASKED`, the interrupt-pending output is held low. The hardware does not save or restore the status byte on interrupt entry or exit; software does that.

The I/O port exposes three byte registers: status, stack pointer high and stack pointer low. The stack pointer also takes push (decrement) and pop (increment) strobes, and it wraps modulo 2^16. Bit-copy support is made of two parts. A bit-store strobe copies a selected operand bit into the transfer cell. A combinational bit-load output returns the operand with the selected bit replaced by the transfer cell.

Top module: `cfu_status_unit`

## Requirements
- R1: After reset, the status byte, both stack pointer bytes and all I/O reads of the three mapped addresses are 0.
- R2: The status byte layout, from bit 7 down to bit 0, is I, T, H, S, V, N, Z, C. It is read and written at I/O address 0x3F. A written S bit is ignored.
- R3: S always equals N XOR V, after ALU updates and after I/O writes.
- R4: ALU flag vector index 0=C, 1=Z, 2=N, 3=V, 4=H. A flag loads its ALU value on the clock edge when its enable bit is 1. Flags whose enable bit is 0 keep their value.
- R5: In a cycle with both an I/O write to 0x3F and ALU flag updates, the I/O write data wins for every flag.
- R6: In the cycle an interrupt is accepted, I is cleared. This takes priority over an I/O write and over a return strobe in the same cycle.
- R7: A return strobe sets I on the next edge. An I/O write to 0x3F in the same cycle takes priority over the return strobe.
- R8: irq_pending equals irq_request while I is 1, and it is 0 while I is 0.
- R9: A bit-store strobe copies operand bit bit_sel (0..7) into T. An I/O write to 0x3F in the same cycle wins.
- R10: bld_result equals the operand with bit bit_sel replaced by T. The output is combinational.
- R11: The stack pointer high byte is at 0x3E and the low byte at 0x3D. Both are readable and writable. Reads of any other address return 0.
- R12: A push strobe decrements the stack pointer and a pop strobe increments it, both modulo 2^16. Push and pop together leave it unchanged. An I/O write to either stack pointer byte in the same cycle replaces the push/pop step: the written byte is loaded and the other byte holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| alu_flag | input | 5 | ALU flag values {H,V,N,Z,C} |
| alu_flag_we | input | 5 | Per-flag update enables, same ordering |
| bst_en | input | 1 | Bit-store strobe: operand bit into T |
| bit_sel | input | 3 | Selected bit index for bit-store and bit-load |
| rf_operand | input | 8 | Register-file operand |
| bld_result | output | 8 | Operand with selected bit replaced by T |
| irq_request | input | 1 | Any individually enabled interrupt is requesting |
| irq_accept | input | 1 | Interrupt taken this cycle |
| irq_return | input | 1 | Return-from-interrupt strobe |
| irq_pending | output | 1 | Request gated by I |
| io_addr | input | 6 | I/O address |
| io_we | input | 1 | I/O write strobe |
| io_wdata | input | 8 | I/O write data |
| io_rdata | output | 8 | I/O read data, combinational |
| sp_push | input | 1 | Decrement stack pointer |
| sp_pop | input | 1 | Increment stack pointer |
| sp_value | output | 16 | Current stack pointer |
| status_out | output | 8 | Current status byte |

## Verification
The registered results take effect on the first rising edge after the stimulus cycle. These are the flags, T, I and the stack pointer. irq_pending, io_rdata and bld_result are combinational in the current state, so they follow the inputs within the same cycle. The bench changes inputs on a falling edge and checks registered results at the next falling edge, one rising edge later. It checks the combinational bit-load output a short delay after driving, with no clock edge in between.

// File: rtl/cfu_pkg.sv
package cfu_pkg;
    localparam int DATA_W    = 8;
    localparam int NUM_FLAGS = 5;   // index 0=C 1=Z 2=N 3=V 4=H

    // bit positions inside the status byte
    localparam int POS_C = 0;
    localparam int POS_Z = 1;
    localparam int POS_N = 2;
    localparam int POS_V = 3;
    localparam int POS_S = 4;
    localparam int POS_H = 5;
    localparam int POS_T = 6;
    localparam int POS_I = 7;

    typedef enum logic {
        IE_MASKED = 1'b0,
        IE_OPEN   = 1'b1
    } ie_state_e;

    // where ALU flag index k lives in the status byte
    function automatic int flag_pos(input int k);
        return (k < 4) ? k : POS_H;
    endfunction
endpackage

// File: rtl/cfu_ie_fsm.sv
module cfu_ie_fsm
    import cfu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic accept,
    input  logic ret,
    input  logic load_en,
    input  logic load_val,
    output logic ie
);
    ie_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= IE_MASKED;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IE_OPEN: begin
                if (accept)                    state_d = IE_MASKED;
                else if (load_en && !load_val) state_d = IE_MASKED;
            end
            IE_MASKED: begin
                if (accept)       state_d = IE_MASKED;
                else if (load_en) state_d = load_val ? IE_OPEN : IE_MASKED;
                else if (ret)     state_d = IE_OPEN;
            end
            default: state_d = IE_MASKED;
        endcase
    end

    always_comb begin
        ie = (state_q == IE_OPEN);
    end

    p_accept_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !ie);
    p_return_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ret && !accept && !load_en) |=> ie);
    p_load_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (load_en && !accept) |=> (ie == $past(load_val)));
endmodule

// File: rtl/cfu_flags.sv
module cfu_flags
    import cfu_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 sr_we,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [NUM_FLAGS-1:0] alu_val,
    input  logic [NUM_FLAGS-1:0] alu_we,
    input  logic                 bst_en,
    input  logic [2:0]           bit_sel,
    input  logic [DATA_W-1:0]    rf_operand,
    output logic                 t_bit,
    output logic [NUM_FLAGS-1:0] flags,
    output logic [DATA_W-1:0]    bld_result
);
    logic [NUM_FLAGS-1:0] flag_q;
    logic                 t_q;

    for (genvar k = 0; k < NUM_FLAGS; k++) begin : g_flag
        localparam int P = flag_pos(k);
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        flag_q[k] <= 1'b0;
            else if (sr_we)    flag_q[k] <= wdata[P];
            else if (alu_we[k]) flag_q[k] <= alu_val[k];
        end

        p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (!sr_we && !alu_we[k]) |=> $stable(flag_q[k]));
        p_io_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
            sr_we |=> (flag_q[k] == $past(wdata[P])));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      t_q <= 1'b0;
        else if (sr_we)  t_q <= wdata[POS_T];
        else if (bst_en) t_q <= rf_operand[bit_sel];
    end

    for (genvar b = 0; b < DATA_W; b++) begin : g_bld
        assign bld_result[b] = (bit_sel == 3'(b)) ? t_q : rf_operand[b];
    end

    assign t_bit = t_q;
    assign flags = flag_q;

    p_bst_copy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bst_en && !sr_we) |=> (t_q == $past(rf_operand[bit_sel])));
endmodule

// File: rtl/cfu_stack_ptr.sv
module cfu_stack_ptr
    import cfu_pkg::*;
#(
    parameter int SP_W = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_hi,
    input  logic              wr_lo,
    input  logic [DATA_W-1:0] wdata,
    input  logic              push,
    input  logic              pop,
    output logic [SP_W-1:0]   sp
);
    localparam int LO_W = DATA_W;
    localparam int HI_W = SP_W - DATA_W;

    logic [SP_W-1:0] sp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sp_q <= '0;
        end else if (wr_hi || wr_lo) begin
            if (wr_hi) sp_q[SP_W-1:LO_W] <= wdata[HI_W-1:0];
            if (wr_lo) sp_q[LO_W-1:0]    <= wdata;
        end else if (push && !pop) begin
            sp_q <= sp_q - 1'b1;
        end else if (pop && !push) begin
            sp_q <= sp_q + 1'b1;
        end
    end

    assign sp = sp_q;

    p_push_dec_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop && !wr_hi && !wr_lo) |=> (sp_q == $past(sp_q) - 1'b1));
    p_pop_inc_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !wr_hi && !wr_lo) |=> (sp_q == $past(sp_q) + 1'b1));
    p_lo_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_lo && !wr_hi) |=> (sp_q[SP_W-1:LO_W] == $past(sp_q[SP_W-1:LO_W])));
endmodule

// File: rtl/cfu_status_unit.sv
module cfu_status_unit
    import cfu_pkg::*;
#(
    parameter int              ADDR_W   = 6,
    parameter logic [ADDR_W-1:0] SR_ADDR  = 6'h3F,
    parameter logic [ADDR_W-1:0] SPH_ADDR = 6'h3E,
    parameter logic [ADDR_W-1:0] SPL_ADDR = 6'h3D
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_FLAGS-1:0] alu_flag,
    input  logic [NUM_FLAGS-1:0] alu_flag_we,
    input  logic                 bst_en,
    input  logic [2:0]           bit_sel,
    input  logic [DATA_W-1:0]    rf_operand,
    output logic [DATA_W-1:0]    bld_result,
    input  logic                 irq_request,
    input  logic                 irq_accept,
    input  logic                 irq_return,
    output logic                 irq_pending,
    input  logic [ADDR_W-1:0]    io_addr,
    input  logic                 io_we,
    input  logic [DATA_W-1:0]    io_wdata,
    output logic [DATA_W-1:0]    io_rdata,
    input  logic                 sp_push,
    input  logic                 sp_pop,
    output logic [2*DATA_W-1:0]  sp_value,
    output logic [DATA_W-1:0]    status_out
);
    localparam int SP_W = 2 * DATA_W;

    logic                 sr_we, sph_we, spl_we;
    logic                 ie, t_bit;
    logic [NUM_FLAGS-1:0] flags;
    logic [SP_W-1:0]      sp;

    assign sr_we  = io_we && (io_addr == SR_ADDR);
    assign sph_we = io_we && (io_addr == SPH_ADDR);
    assign spl_we = io_we && (io_addr == SPL_ADDR);

    cfu_ie_fsm u_ie (
        .clk      (clk),
        .rst_n    (rst_n),
        .accept   (irq_accept),
        .ret      (irq_return),
        .load_en  (sr_we),
        .load_val (io_wdata[POS_I]),
        .ie       (ie)
    );

    cfu_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .sr_we      (sr_we),
        .wdata      (io_wdata),
        .alu_val    (alu_flag),
        .alu_we     (alu_flag_we),
        .bst_en     (bst_en),
        .bit_sel    (bit_sel),
        .rf_operand (rf_operand),
        .t_bit      (t_bit),
        .flags      (flags),
        .bld_result (bld_result)
    );

    cfu_stack_ptr #(.SP_W(SP_W)) u_sp (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_hi (sph_we),
        .wr_lo (spl_we),
        .wdata (io_wdata),
        .push  (sp_push),
        .pop   (sp_pop),
        .sp    (sp)
    );

    always_comb begin
        status_out        = '0;
        status_out[POS_I] = ie;
        status_out[POS_T] = t_bit;
        status_out[POS_H] = flags[4];
        status_out[POS_V] = flags[3];
        status_out[POS_N] = flags[2];
        status_out[POS_Z] = flags[1];
        status_out[POS_C] = flags[0];
        status_out[POS_S] = flags[3] ^ flags[2];
    end

    always_comb begin
        if (io_addr == SR_ADDR)       io_rdata = status_out;
        else if (io_addr == SPH_ADDR) io_rdata = sp[SP_W-1:DATA_W];
        else if (io_addr == SPL_ADDR) io_rdata = sp[DATA_W-1:0];
        else                          io_rdata = '0;
    end

    assign irq_pending = irq_request && ie;
    assign sp_value    = sp;

    p_pending_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !status_out[POS_I] |-> !irq_pending);
endmodule

// File: tb/sim_cfu_status_unit.sv
module sim_cfu_status_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  alu_flag = '0, alu_flag_we = '0;
    logic        bst_en = 1'b0;
    logic [2:0]  bit_sel = '0;
    logic [7:0]  rf_operand = '0;
    logic [7:0]  bld_result;
    logic        irq_request = 1'b0, irq_accept = 1'b0, irq_return = 1'b0;
    logic        irq_pending;
    logic [5:0]  io_addr = '0;
    logic        io_we = 1'b0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        sp_push = 1'b0, sp_pop = 1'b0;
    logic [15:0] sp_value;
    logic [7:0]  status_out;

    int checks = 0, fails = 0;
    bit done = 0;

    // bench model
    logic        m_i = 0, m_t = 0;
    logic [4:0]  m_f = '0;     // {H,V,N,Z,C}
    logic [15:0] m_sp = '0;

    always #2 clk = ~clk;   // 250 MHz

    cfu_status_unit u0 (.*);

    function automatic logic [7:0] m_sreg();
        return {m_i, m_t, m_f[4], m_f[3] ^ m_f[2], m_f[3], m_f[2], m_f[1], m_f[0]};
    endfunction

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        alu_flag_we = '0; bst_en = 0; irq_accept = 0; irq_return = 0;
        io_we = 0; sp_push = 0; sp_pop = 0;
    endtask

    task automatic io_write(input logic [5:0] a, input logic [7:0] d);
        io_addr = a; io_wdata = d; io_we = 1;
        tick();
        idle();
        if (a == 6'h3F) begin
            m_i = d[7]; m_t = d[6];
            m_f = {d[5], d[3], d[2], d[1], d[0]};
        end else if (a == 6'h3E) m_sp[15:8] = d;
        else if (a == 6'h3D) m_sp[7:0] = d;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk("R1 status", {8'h0, status_out}, 16'h0);
        chk("R1 sp", sp_value, 16'h0);
        io_addr = 6'h3F; #1 chk("R1 rd3F", {8'h0, io_rdata}, 16'h0);
        io_addr = 6'h3E; #1 chk("R1 rd3E", {8'h0, io_rdata}, 16'h0);
        io_addr = 6'h3D; #1 chk("R1 rd3D", {8'h0, io_rdata}, 16'h0);

        // R2 / R3 sweep of every write value
        for (int w = 0; w < 256; w++) begin
            io_write(6'h3F, 8'(w));
            io_addr = 6'h3F; #1;
            chk("R2 readback", {8'h0, io_rdata}, {8'h0, m_sreg()});
            chk("R3 sign", {15'h0, status_out[4]}, {15'h0, status_out[3] ^ status_out[2]});
        end

        // R4 / R3 all enables x all values
        io_write(6'h3F, 8'h00);
        for (int en = 0; en < 32; en++) begin
            for (int v = 0; v < 32; v++) begin
                alu_flag = 5'(v); alu_flag_we = 5'(en);
                tick();
                idle();
                for (int k = 0; k < 5; k++) if (en[k]) m_f[k] = v[k];
                chk("R4 flags", {8'h0, status_out}, {8'h0, m_sreg()});
                chk("R3 sign", {15'h0, status_out[4]}, {15'h0, m_f[3] ^ m_f[2]});
            end
        end

        // R5 io write beats ALU update
        alu_flag = 5'h1F; alu_flag_we = 5'h1F;
        io_addr = 6'h3F; io_wdata = 8'h00; io_we = 1;
        tick(); idle();
        m_i = 0; m_t = 0; m_f = '0;
        chk("R5 io priority", {8'h0, status_out}, 16'h0);
        alu_flag = 5'h00; alu_flag_we = 5'h1F;
        io_wdata = 8'h2F; io_we = 1;
        tick(); idle();
        chk("R5 io priority2", {8'h0, status_out}, 16'h002F);

        // R8 masking, R7 return, R6 accept
        io_write(6'h3F, 8'h00);
        irq_request = 1; #1;
        chk("R8 masked", {15'h0, irq_pending}, 16'h0);
        irq_return = 1; tick(); idle();
        chk("R7 I set", {15'h0, status_out[7]}, 16'h1);
        chk("R8 pass", {15'h0, irq_pending}, 16'h1);
        irq_request = 0; #1;
        chk("R8 no request", {15'h0, irq_pending}, 16'h0);
        irq_request = 1;
        irq_accept = 1; tick(); idle();
        chk("R6 I cleared", {15'h0, status_out[7]}, 16'h0);
        chk("R8 masked after accept", {15'h0, irq_pending}, 16'h0);
        irq_return = 1; irq_accept = 1; tick(); idle();
        chk("R6 accept beats return", {15'h0, status_out[7]}, 16'h0);
        irq_accept = 1; io_addr = 6'h3F; io_wdata = 8'hC1; io_we = 1;
        tick(); idle();
        chk("R6 accept beats write", {8'h0, status_out}, 16'h0041);
        irq_return = 1; tick(); idle();
        chk("R7 return", {15'h0, status_out[7]}, 16'h1);
        irq_return = 1; io_addr = 6'h3F; io_wdata = 8'h00; io_we = 1;
        tick(); idle();
        chk("R7 write beats return", {15'h0, status_out[7]}, 16'h0);
        irq_request = 0;
        m_i = 0; m_t = 0; m_f = '0;

        // R9 bit-store
        for (int s = 0; s < 8; s++) begin
            for (int p = 0; p < 4; p++) begin
                logic [7:0] op;
                op = 8'(8'h5A ^ (p * 8'h3C) ^ (1 << s));
                rf_operand = op; bit_sel = 3'(s); bst_en = 1;
                tick(); idle();
                chk("R9 bst", {15'h0, status_out[6]}, {15'h0, op[s]});
            end
        end
        rf_operand = 8'hFF; bit_sel = 3'd2; bst_en = 1;
        io_addr = 6'h3F; io_wdata = 8'h00; io_we = 1;
        tick(); idle();
        chk("R9 write beats bst", {15'h0, status_out[6]}, 16'h0);

        // R10 bit-load sweep
        for (int t = 0; t < 2; t++) begin
            io_write(6'h3F, t ? 8'h40 : 8'h00);
            for (int op = 0; op < 256; op++) begin
                for (int s = 0; s < 8; s++) begin
                    logic [7:0] e;
                    e = 8'(op);
                    e[s] = t[0];
                    rf_operand = 8'(op); bit_sel = 3'(s);
                    #1 chk("R10 bld", {8'h0, bld_result}, {8'h0, e});
                end
            end
        end

        // R11 stack pointer bytes
        io_write(6'h3E, 8'hA5);
        io_write(6'h3D, 8'h5A);
        io_addr = 6'h3E; #1 chk("R11 rd hi", {8'h0, io_rdata}, 16'h00A5);
        io_addr = 6'h3D; #1 chk("R11 rd lo", {8'h0, io_rdata}, 16'h005A);
        chk("R11 sp", sp_value, 16'hA55A);
        io_addr = 6'h10; #1 chk("R11 unmapped", {8'h0, io_rdata}, 16'h0);

        // R12 push/pop
        io_write(6'h3E, 8'h00);
        io_write(6'h3D, 8'h00);
        sp_push = 1; tick(); idle();
        chk("R12 push wrap", sp_value, 16'hFFFF);
        sp_pop = 1; tick(); idle();
        chk("R12 pop wrap", sp_value, 16'h0000);
        sp_push = 1; sp_pop = 1; tick(); idle();
        chk("R12 both", sp_value, 16'h0000);
        io_write(6'h3E, 8'h12);
        sp_push = 1; io_addr = 6'h3D; io_wdata = 8'h34; io_we = 1;
        tick(); idle();
        chk("R12 write beats push", sp_value, 16'h1234);
        m_sp = 16'h1234;
        for (int n = 0; n < 600; n++) begin
            if (n % 3 == 2) begin sp_pop = 1; m_sp = m_sp + 1; end
            else begin sp_push = 1; m_sp = m_sp - 1; end
            tick(); idle();
            chk("R12 sequence", sp_value, m_sp);
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule